// File: doc/BRIEF.md
# Reset-Aligned Selectable Clock Divider

This block turns a fast source clock into a slower system clock whose ratio is chosen from divide-by-2, divide-by-4 and divide-by-8. It is built as a counter clocked by the fast clock. Its divided output is intended as a primary clock source fed from a high-speed edge clock or a PLL output.

Both outputs stay low through reset and after it. They start only when an explicit release strobe is sampled. Counting then begins from a fixed phase, so every reset-and-release sequence gives the same edge alignment between the divided clock and the source.

A one-cycle enable pulse in the fast domain marks every rising edge of the divided clock. Logic in the fast domain can use it as a phase reference. The interface carries no data stream, so every pin is a plain control or status signal.

Top module: `phased_clk_divider`

## Requirements
- R1: The ratio select is sampled in the same fast-clock cycle in which release is accepted. Code 0 selects divide-by-2, code 1 selects divide-by-4, and codes 2 and 3 both select divide-by-8. The divided clock then has a period of N fast cycles, where N is the selected ratio.
- R2: While reset is high, both outputs are low. Raising reset clears them at once, without waiting for a clock edge.
- R3: After reset is removed, both outputs stay low until a release is accepted.
- R4: A release is sampled on a rising fast-clock edge. The divided clock rises on the next rising edge, and the enable pulses on that same edge.
- R5: The divided clock is high for N/2 fast cycles and then low for N/2 fast cycles, repeating.
- R6: The enable output is high for exactly one fast cycle, on each cycle in which the divided clock has just risen, and at no other time.
- R7: While the divider runs, changes on the ratio select and further release pulses have no effect on either output.
- R8: Two reset-and-release sequences with the same ratio give the same output pattern, counted in fast cycles from the edge that samples release.
- R9: Reset is removed in step with the fast clock. A release sampled on either of the first two rising edges after reset falls is ignored. A release sampled on the third such edge is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast_i | input | 1 | Fast source clock |
| rst_i | input | 1 | Active-high reset, asynchronous assertion |
| release_i | input | 1 | Strobe that starts the divider from its fixed phase |
| ratio_sel_i | input | 2 | Divide ratio code, sampled with release |
| clk_div_o | output | 1 | Divided clock |
| div_en_o | output | 1 | One-cycle pulse on each divided-clock rising edge |

## Verification
A wrong counter state shows up at the ports within one divided period, as a high or low phase that is too long or too short. The same fault shows as an enable pulse that drifts away from the rising edge. A wrongly latched or unlatched ratio changes the period as early as the first cycle after release, or the first cycle after a mid-run select change. A fault in the arming or reset-release path shows as a rising edge one cycle early or late, or as outputs that move before release. Each of these is visible on the first fast edge at which it occurs.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // Map a select code onto a divide ratio 2^(code+1); codes past the top saturate.
  function automatic int unsigned ratio_of(input int unsigned code, input int unsigned num_ratios);
    int unsigned c;
    c = (code >= num_ratios) ? (num_ratios - 1) : code;
    return 32'd2 << c;
  endfunction
endpackage

// File: rtl/cdiv_rst_sync.sv
module cdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async,
  output logic rst_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or posedge rst_async) begin
    if (rst_async) chain_q <= '1;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b0};
  end

  assign rst_sync = chain_q[STAGES-1];

  // R2: the synced reset follows the raw reset asynchronously
  assert_rst_follow_R2: assert property (@(posedge clk) $past(rst_async) |-> rst_sync);
endmodule

// File: rtl/cdiv_arm.sv
module cdiv_arm
  import clkdiv_pkg::*;
#(
  parameter int SEL_W      = 2,
  parameter int NUM_RATIOS = 3,
  parameter int CNT_W      = NUM_RATIOS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             release_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             start_o,
  output logic             running_o,
  output logic [CNT_W-1:0] last_o,
  output logic [CNT_W-1:0] half_o
);
  localparam int RW = CNT_W + 1;

  logic             pend_q;
  logic             run_q;
  logic [RW-1:0]    ratio_q;
  logic [RW-1:0]    ratio_d;

  always_comb ratio_d = RW'(ratio_of(int'(sel_i), NUM_RATIOS));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pend_q  <= 1'b0;
      run_q   <= 1'b0;
      ratio_q <= RW'(2);
    end else begin
      pend_q <= release_i & ~run_q & ~pend_q;
      if (release_i & ~run_q & ~pend_q) ratio_q <= ratio_d;
      if (pend_q) run_q <= 1'b1;
    end
  end

  assign start_o   = pend_q;
  assign running_o = run_q;
  assign last_o    = CNT_W'(ratio_q - RW'(1));
  assign half_o    = CNT_W'(ratio_q >> 1);

  // R7: the latched ratio cannot move once running
  assert_ratio_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q)) |-> $stable(ratio_q));
  // R4: the start pulse lasts exactly one cycle
  assert_start_single_R4: assert property (@(posedge clk) disable iff (rst)
    pend_q |=> !pend_q);
endmodule

// File: rtl/cdiv_count.sv
module cdiv_count #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             running_i,
  input  logic [CNT_W-1:0] last_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             div_o,
  output logic             en_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             div_q;
  logic             en_q;

  always_comb cnt_nxt = (cnt_q == last_i) ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt_q <= '0;
      div_q <= 1'b0;
      en_q  <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      div_q <= 1'b1;
      en_q  <= 1'b1;
    end else if (running_i) begin
      cnt_q <= cnt_nxt;
      div_q <= (cnt_nxt < half_i);
      en_q  <= (cnt_nxt == '0);
    end else begin
      cnt_q <= '0;
      div_q <= 1'b0;
      en_q  <= 1'b0;
    end
  end

  assign div_o = div_q;
  assign en_o  = en_q;

  // checker: length of the current high phase before this cycle
  logic [CNT_W:0] hi_run_q;
  always_ff @(posedge clk or posedge rst) begin
    if (rst)        hi_run_q <= '0;
    else if (div_q) hi_run_q <= hi_run_q + 1'b1;
    else            hi_run_q <= '0;
  end

  // R5: a high phase never exceeds half the ratio
  assert_high_len_R5: assert property (@(posedge clk) disable iff (rst)
    div_q |-> (hi_run_q < {1'b0, half_i}));
endmodule

// File: rtl/phased_clk_divider.sv
module phased_clk_divider #(
  parameter int SEL_W       = 2,
  parameter int NUM_RATIOS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_fast_i,
  input  logic             rst_i,
  input  logic             release_i,
  input  logic [SEL_W-1:0] ratio_sel_i,
  output logic             clk_div_o,
  output logic             div_en_o
);
  localparam int CNT_W = NUM_RATIOS;

  logic             rst_s;
  logic             start;
  logic             running;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] half;

  cdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_fast_i), .rst_async(rst_i), .rst_sync(rst_s)
  );

  cdiv_arm #(.SEL_W(SEL_W), .NUM_RATIOS(NUM_RATIOS), .CNT_W(CNT_W)) u_arm (
    .clk(clk_fast_i), .rst(rst_s), .release_i(release_i), .sel_i(ratio_sel_i),
    .start_o(start), .running_o(running), .last_o(last), .half_o(half)
  );

  cdiv_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk_fast_i), .rst(rst_s), .start_i(start), .running_i(running),
    .last_i(last), .half_i(half), .div_o(clk_div_o), .en_o(div_en_o)
  );

  // R2: outputs low through reset
  assert_rst_low_R2: assert property (@(posedge clk_fast_i)
    $past(rst_i) |-> (!clk_div_o && !div_en_o));
  // R3: nothing moves before a release is accepted
  assert_idle_low_R3: assert property (@(posedge clk_fast_i) disable iff (rst_s)
    (!running && !start) |-> (!clk_div_o && !div_en_o));
  // R6: enable only on the cycle the divided clock has just risen
  assert_en_edge_R6: assert property (@(posedge clk_fast_i) disable iff (rst_s)
    div_en_o |-> (clk_div_o && !$past(clk_div_o)));
  // R6: every rise carries an enable
  assert_rise_en_R6: assert property (@(posedge clk_fast_i) disable iff (rst_s)
    $rose(clk_div_o) |-> div_en_o);
  // R4: first rise follows the accepted release by one edge
  assert_first_rise_R4: assert property (@(posedge clk_fast_i) disable iff (rst_s)
    start |=> (clk_div_o && div_en_o));
endmodule

// File: tb/phased_clk_divider_tb.sv
module phased_clk_divider_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       rel;
  logic [1:0] sel;
  logic       div_o, en_o;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phased_clk_divider u_dut (
    .clk_fast_i(clk), .rst_i(rst), .release_i(rel), .ratio_sel_i(sel),
    .clk_div_o(div_o), .div_en_o(en_o)
  );

  task automatic chk(input string req, input logic act_d, input logic exp_d,
                     input logic act_e, input logic exp_e);
    checks++;
    if (act_d !== exp_d || act_e !== exp_e) begin
      fails++;
      $display("FAIL %s t=%0t div=%b/%b en=%b/%b (actual/expected)", req, $time,
               act_d, exp_d, act_e, exp_e);
    end
  endtask

  function automatic int ratio(input int code);
    return (code >= 2) ? 8 : (2 << code);
  endfunction

  // reset, wait out the sync window, release and follow the pattern
  task automatic run_seq(input int code, input bit mid_change);
    int n;
    n = ratio(code);
    rst = 1'b1; rel = 1'b0; sel = 2'(code);
    repeat (3) @(negedge clk);
    chk("R2", div_o, 1'b0, en_o, 1'b0);
    rst = 1'b0;
    repeat (6) begin
      @(negedge clk);
      chk("R3", div_o, 1'b0, en_o, 1'b0);
    end
    rel = 1'b1;
    @(negedge clk);
    rel = 1'b0;
    chk("R4", div_o, 1'b0, en_o, 1'b0);
    @(negedge clk);
    for (int t = 0; t < 4*n; t++) begin
      chk(mid_change ? "R7" : ((t % n == 0) ? "R6" : "R5"),
          div_o, logic'((t % n) < n/2), en_o, logic'((t % n) == 0));
      if (mid_change && t == n + 1) begin sel = 2'(code ^ 1); rel = 1'b1; end
      if (mid_change && t == n + 2) rel = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    rst = 1'b1; rel = 1'b0; sel = '0;
    #1;
    chk("R2", div_o, 1'b0, en_o, 1'b0);
    // R1 / R5 / R6: every select code
    for (int c = 0; c < 4; c++) run_seq(c, 1'b0);
    // R8: repeat of same ratio gives identical pattern
    run_seq(1, 1'b0);
    run_seq(1, 1'b0);
    // R7: mid-run select change and extra release ignored
    run_seq(0, 1'b1);
    run_seq(2, 1'b1);
    // R2: async assertion while running
    @(negedge clk);
    #2 rst = 1'b1;
    #1 chk("R2", div_o, 1'b0, en_o, 1'b0);
    // R9: release on the first two edges after reset falls is lost
    @(negedge clk);
    sel = 2'd1;
    rst = 1'b0; rel = 1'b1;
    repeat (2) @(negedge clk);
    rel = 1'b0;
    repeat (10) begin
      @(negedge clk);
      chk("R9", div_o, 1'b0, en_o, 1'b0);
    end
    // R9: third edge accepted
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    rel = 1'b1;
    @(negedge clk);
    rel = 1'b0;
    chk("R9", div_o, 1'b0, en_o, 1'b0);
    @(negedge clk);
    chk("R9", div_o, 1'b1, en_o, 1'b1);
    @(negedge clk);
    chk("R9", div_o, 1'b1, en_o, 1'b0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule